// File: doc/BRIEF.md
# OSD Serial Command Receiver

This block is the host-facing front end of an on-screen display controller. A host drives three wires (an active-low select, a shift clock and a data line), and the block assembles them into 8-bit words. Each word is then sorted as a command byte, a data byte for the current command, or a character for the display memory. The three serial wires are asynchronous to the system clock and are synchronized inside the block.

A command byte is remembered, and every data byte after it is reported on a register-write strobe together with the command index and the low nibble of that command byte. Downstream position, size and control registers decode this strobe. One command puts the receiver into a character mode. In that mode every byte becomes a write to a character memory of ROWS by COLS cells, and the write position advances by one cell after each write. The character mode lasts until select is released. Releasing select always returns the receiver to the address-setup command.

Top module: `osd_cmd_rx`

## Requirements
- R1: A word is 8 bits, shifted in MSB first on rising edges of `ser_clk`, and only while `ser_cs_n` is low. Bits collected before `ser_cs_n` rises, when fewer than 8 have arrived, are dropped and produce no strobe.
- R2: Outside character mode, a word with bit 7 = 1 is a command byte. When bits 7:4 are 1000 to 1110, the command index is bits 6:4 (0 to 6). When bits 7:4 are 1111, the index is 7 plus bits 3:0. A command byte produces no strobe by itself.
- R3: Outside character mode, a word with bit 7 = 0 is a data byte. It pulses `reg_stb` for one cycle, with `reg_cmd` set to the held command index, `reg_hdr` set to bits 3:0 of that command byte and `reg_data` set to bits 6:0 of the word. The held command stays in force for any number of data bytes.
- R4: Command 0 sets the write position. Its command byte loads the row from bits 3:0, and its data bytes load the column from bits 4:0. A row of ROWS or above, or a column of COLS or above, leaves that coordinate unchanged.
- R5: A command byte whose bits 7:4 are 1001 (index 1) enters character mode. In that mode every later word is a character, bit 7 is an attribute and bits 6:0 are the code, even when bit 7 is 1. No command is decoded and `reg_stb` stays low.
- R6: A rise of `ser_cs_n` leaves character mode and makes command 0 the held command with a zero header nibble. The write position is kept, so the next data byte sets the column.
- R7: Each character pulses `ram_we` for one cycle. `ram_wdata` carries the whole word (attribute in bit 7, code in bits 6:0), and `ram_row`/`ram_col` carry the position in force before that write.
- R8: After each character the column advances by one. After column COLS-1 it wraps to column 0 of the next row, and after row ROWS-1 it wraps to row 0.
- R9: A synchronous high `rst` clears every register. All outputs read zero, character mode is off and command 0 is held.
- R10: Each completed word yields at most one strobe, and `ram_we` and `reg_stb` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_cs_n | input | 1 | Serial select, active low, asynchronous |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_din | input | 1 | Serial data, MSB first |
| ram_we | output | 1 | Character memory write strobe |
| ram_row | output | $clog2(ROWS) | Row of the character write |
| ram_col | output | $clog2(COLS) | Column of the character write |
| ram_wdata | output | 8 | Attribute bit and 7-bit character code |
| reg_stb | output | 1 | Register-write strobe for a data byte |
| reg_cmd | output | 5 | Command index held for the data byte |
| reg_hdr | output | 4 | Low nibble of the held command byte |
| reg_data | output | 7 | Payload bits 6:0 of the data byte |

## Verification
Some rules are checked on every cycle by the assertions. No word is framed while select is high. The strobes are single and mutually exclusive. A locked word always becomes a character. Release clears the lock. The held command is stable across data bytes. The position stays in range and wraps correctly from the last cell. Other behaviour only shows up in the bench's byte sequences, which are compared event by event against a behavioural model: the command index mapping, header capture, rejection of out-of-range coordinates, dropping of partial words, a 0x90 byte treated as a character inside character mode, and reset in the middle of a select period.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;

  localparam int BYTE_W  = 8;
  localparam int CMD_W   = 5;
  localparam int HDR_W   = 4;
  localparam int PAY_W   = 7;
  localparam int COLV_W  = 5;

  localparam logic [CMD_W-1:0] CMD_ADDR = 5'd0;
  localparam logic [CMD_W-1:0] CMD_CHAR = 5'd1;

  // Map a command byte to its command index.
  function automatic logic [CMD_W-1:0] cmd_index(input logic [BYTE_W-1:0] b);
    if (b[7:4] == 4'hF) begin
      return 5'd7 + {1'b0, b[3:0]};
    end
    return {2'b00, b[6:4]};
  endfunction

endpackage

// File: rtl/osd_ser_shift.sv
module osd_ser_shift #(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdin_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o,
  output logic              release_o
);

  localparam int CNT_W = $clog2(WORD_W);

  logic [SYNC_STAGES-1:0] cs_pipe, clk_pipe, dat_pipe;
  logic                   cs_s, clk_s, dat_s;
  logic                   cs_q, clk_q;
  logic [CNT_W-1:0]       bit_cnt;
  logic [WORD_W-2:0]      shreg;

  // Synchronizers for the three asynchronous serial wires
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_pipe  <= '1;
      clk_pipe <= '0;
      dat_pipe <= '0;
    end else begin
      cs_pipe[0]  <= cs_n_i;
      clk_pipe[0] <= sclk_i;
      dat_pipe[0] <= sdin_i;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        cs_pipe[i]  <= cs_pipe[i-1];
        clk_pipe[i] <= clk_pipe[i-1];
        dat_pipe[i] <= dat_pipe[i-1];
      end
    end
  end

  assign cs_s  = cs_pipe[SYNC_STAGES-1];
  assign clk_s = clk_pipe[SYNC_STAGES-1];
  assign dat_s = dat_pipe[SYNC_STAGES-1];

  // Edge detection, shifting and word framing
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q       <= 1'b1;
      clk_q      <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
      release_o  <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      release_o  <= cs_s & ~cs_q;
      cs_q       <= cs_s;
      clk_q      <= clk_s;
      if (cs_s) begin
        bit_cnt <= '0;
      end else if (clk_s && !clk_q) begin
        if (bit_cnt == CNT_W'(WORD_W - 1)) begin
          word_o     <= {shreg, dat_s};
          word_vld_o <= 1'b1;
          bit_cnt    <= '0;
        end else begin
          shreg   <= {shreg[WORD_W-3:0], dat_s};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R1: no word is framed while select is released
  p_no_word_idle_r1: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !word_vld_o);

  // R10: a framed word is a single-cycle pulse
  p_word_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |=> !word_vld_o);

  // R6: release and a framed word never coincide
  p_release_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(release_o && word_vld_o));

endmodule

// File: rtl/osd_cmd_decode.sv
module osd_cmd_decode
  import osd_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld_i,
  input  logic [BYTE_W-1:0] word_i,
  input  logic              release_i,
  output logic              char_stb_o,
  output logic [BYTE_W-1:0] char_data_o,
  output logic              row_ld_o,
  output logic [HDR_W-1:0]  row_val_o,
  output logic              col_ld_o,
  output logic [COLV_W-1:0] col_val_o,
  output logic              reg_stb_o,
  output logic [CMD_W-1:0]  reg_cmd_o,
  output logic [HDR_W-1:0]  reg_hdr_o,
  output logic [PAY_W-1:0]  reg_data_o
);

  logic             lock_q;
  logic [CMD_W-1:0] cmd_q;
  logic [HDR_W-1:0] hdr_q;
  logic [CMD_W-1:0] new_cmd;

  assign new_cmd = cmd_index(word_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q      <= 1'b0;
      cmd_q       <= CMD_ADDR;
      hdr_q       <= '0;
      char_stb_o  <= 1'b0;
      char_data_o <= '0;
      row_ld_o    <= 1'b0;
      row_val_o   <= '0;
      col_ld_o    <= 1'b0;
      col_val_o   <= '0;
      reg_stb_o   <= 1'b0;
      reg_cmd_o   <= '0;
      reg_hdr_o   <= '0;
      reg_data_o  <= '0;
    end else begin
      char_stb_o <= 1'b0;
      row_ld_o   <= 1'b0;
      col_ld_o   <= 1'b0;
      reg_stb_o  <= 1'b0;
      if (release_i) begin
        lock_q <= 1'b0;
        cmd_q  <= CMD_ADDR;
        hdr_q  <= '0;
      end else if (word_vld_i) begin
        if (lock_q) begin
          char_stb_o  <= 1'b1;
          char_data_o <= word_i;
        end else if (word_i[BYTE_W-1]) begin
          cmd_q <= new_cmd;
          hdr_q <= word_i[HDR_W-1:0];
          if (new_cmd == CMD_ADDR) begin
            row_ld_o  <= 1'b1;
            row_val_o <= word_i[HDR_W-1:0];
          end
          if (new_cmd == CMD_CHAR) begin
            lock_q <= 1'b1;
          end
        end else begin
          reg_stb_o  <= 1'b1;
          reg_cmd_o  <= cmd_q;
          reg_hdr_o  <= hdr_q;
          reg_data_o <= word_i[PAY_W-1:0];
          if (cmd_q == CMD_ADDR) begin
            col_ld_o  <= 1'b1;
            col_val_o <= word_i[COLV_W-1:0];
          end
        end
      end
    end
  end

  // R5: every word in character mode becomes a character, never a register write
  p_lock_char_r5: assert property (@(posedge clk) disable iff (rst)
    (lock_q && word_vld_i && !release_i) |=> (char_stb_o && !reg_stb_o));

  // R6: release always drops the lock and restores command 0
  p_release_clear_r6: assert property (@(posedge clk) disable iff (rst)
    release_i |=> (!lock_q && cmd_q == CMD_ADDR));

  // R3: a data byte leaves the held command untouched
  p_cmd_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (word_vld_i && !word_i[BYTE_W-1] && !lock_q && !release_i) |=> $stable(cmd_q));

  // R10: at most one kind of strobe per cycle
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({char_stb_o, reg_stb_o, row_ld_o}));

endmodule

// File: rtl/osd_wr_addr.sv
module osd_wr_addr
  import osd_cmd_pkg::*;
#(
  parameter int ROWS = 12,
  parameter int COLS = 24,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              row_ld_i,
  input  logic [HDR_W-1:0]  row_val_i,
  input  logic              col_ld_i,
  input  logic [COLV_W-1:0] col_val_i,
  input  logic              char_stb_i,
  input  logic [BYTE_W-1:0] char_data_i,
  output logic              ram_we_o,
  output logic [ROW_W-1:0]  ram_row_o,
  output logic [COL_W-1:0]  ram_col_o,
  output logic [BYTE_W-1:0] ram_wdata_o
);

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             row_last, col_last;

  assign row_last = (row_q == ROW_W'(ROWS - 1));
  assign col_last = (col_q == COL_W'(COLS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q       <= '0;
      col_q       <= '0;
      ram_we_o    <= 1'b0;
      ram_row_o   <= '0;
      ram_col_o   <= '0;
      ram_wdata_o <= '0;
    end else begin
      ram_we_o <= 1'b0;
      if (row_ld_i && (int'(row_val_i) < ROWS)) begin
        row_q <= ROW_W'(row_val_i);
      end
      if (col_ld_i && (int'(col_val_i) < COLS)) begin
        col_q <= COL_W'(col_val_i);
      end
      if (char_stb_i) begin
        ram_we_o    <= 1'b1;
        ram_row_o   <= row_q;
        ram_col_o   <= col_q;
        ram_wdata_o <= char_data_i;
        if (col_last) begin
          col_q <= '0;
          row_q <= row_last ? '0 : row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  // R8: position stays inside the character grid
  p_pos_range_r8: assert property (@(posedge clk) disable iff (rst)
    (int'(row_q) < ROWS) && (int'(col_q) < COLS));

  // R8: last cell wraps to the first
  p_grid_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (char_stb_i && row_last && col_last) |=> (row_q == '0 && col_q == '0));

  // R7: a write strobe lasts one cycle
  p_we_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    ram_we_o |=> !ram_we_o);

  // R9: reset clears the position and the strobe
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (row_q == '0 && col_q == '0 && !ram_we_o));

endmodule

// File: rtl/osd_cmd_rx.sv
module osd_cmd_rx
  import osd_cmd_pkg::*;
#(
  parameter int ROWS        = 12,
  parameter int COLS        = 24,
  parameter int SYNC_STAGES = 2,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_cs_n,
  input  logic             ser_clk,
  input  logic             ser_din,
  output logic             ram_we,
  output logic [ROW_W-1:0] ram_row,
  output logic [COL_W-1:0] ram_col,
  output logic [7:0]       ram_wdata,
  output logic             reg_stb,
  output logic [4:0]       reg_cmd,
  output logic [3:0]       reg_hdr,
  output logic [6:0]       reg_data
);

  logic              word_vld, release_p;
  logic [BYTE_W-1:0] word;
  logic              char_stb, row_ld, col_ld;
  logic [BYTE_W-1:0] char_data;
  logic [HDR_W-1:0]  row_val;
  logic [COLV_W-1:0] col_val;

  osd_ser_shift #(
    .WORD_W      (BYTE_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_shift (
    .clk        (clk),
    .rst        (rst),
    .cs_n_i     (ser_cs_n),
    .sclk_i     (ser_clk),
    .sdin_i     (ser_din),
    .word_vld_o (word_vld),
    .word_o     (word),
    .release_o  (release_p)
  );

  osd_cmd_decode u_decode (
    .clk         (clk),
    .rst         (rst),
    .word_vld_i  (word_vld),
    .word_i      (word),
    .release_i   (release_p),
    .char_stb_o  (char_stb),
    .char_data_o (char_data),
    .row_ld_o    (row_ld),
    .row_val_o   (row_val),
    .col_ld_o    (col_ld),
    .col_val_o   (col_val),
    .reg_stb_o   (reg_stb),
    .reg_cmd_o   (reg_cmd),
    .reg_hdr_o   (reg_hdr),
    .reg_data_o  (reg_data)
  );

  osd_wr_addr #(
    .ROWS (ROWS),
    .COLS (COLS)
  ) u_addr (
    .clk         (clk),
    .rst         (rst),
    .row_ld_i    (row_ld),
    .row_val_i   (row_val),
    .col_ld_i    (col_ld),
    .col_val_i   (col_val),
    .char_stb_i  (char_stb),
    .char_data_i (char_data),
    .ram_we_o    (ram_we),
    .ram_row_o   (ram_row),
    .ram_col_o   (ram_col),
    .ram_wdata_o (ram_wdata)
  );

  // R10: character write and register write never coincide at the ports
  p_port_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && reg_stb));

endmodule

// File: tb/osd_cmd_rx_tb.sv
module osd_cmd_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HP         = 4;
  localparam int ROWS       = 12;
  localparam int COLS       = 24;
  localparam int WDOG       = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_cs_n = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_din = 1'b0;
  logic       ram_we;
  logic [3:0] ram_row;
  logic [4:0] ram_col;
  logic [7:0] ram_wdata;
  logic       reg_stb;
  logic [4:0] reg_cmd;
  logic [3:0] reg_hdr;
  logic [6:0] reg_data;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  string cur_req = "R9";

  // behavioural model state
  int exp_q[$];
  int m_row = 0, m_col = 0, m_cmd = 0, m_hdr = 0;
  bit m_lock = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osd_cmd_rx #(.ROWS(ROWS), .COLS(COLS)) dut_i (
    .clk(clk), .rst(rst), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ram_we(ram_we), .ram_row(ram_row), .ram_col(ram_col), .ram_wdata(ram_wdata),
    .reg_stb(reg_stb), .reg_cmd(reg_cmd), .reg_hdr(reg_hdr), .reg_data(reg_data)
  );

  task automatic check_eq(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    m_row = 0; m_col = 0; m_cmd = 0; m_hdr = 0; m_lock = 0;
  endtask

  task automatic model_word(input int b);
    if (m_lock) begin
      exp_q.push_back((1 << 23) | (m_row << 16) | (m_col << 8) | b);
      m_col++;
      if (m_col == COLS) begin
        m_col = 0;
        m_row = (m_row == ROWS - 1) ? 0 : m_row + 1;
      end
    end else if (b >= 128) begin
      m_cmd = ((b >> 4) == 15) ? 7 + (b & 15) : ((b >> 4) & 7);
      m_hdr = b & 15;
      if (m_cmd == 0 && (b & 15) < ROWS) m_row = b & 15;
      if (m_cmd == 1) m_lock = 1;
    end else begin
      exp_q.push_back((m_cmd << 16) | (m_hdr << 8) | (b & 127));
      if (m_cmd == 0 && (b & 31) < COLS) m_col = b & 31;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input int v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = v[i];
      wait_clk(HP);
      ser_clk = 1'b1;
      wait_clk(HP);
      ser_clk = 1'b0;
    end
    wait_clk(HP);
  endtask

  task automatic send_byte(input int b);
    model_word(b);
    send_bits(b, 8);
  endtask

  task automatic cs_low();
    ser_cs_n = 1'b0;
    wait_clk(HP);
  endtask

  task automatic cs_high();
    ser_cs_n = 1'b1;
    m_lock = 0; m_cmd = 0; m_hdr = 0;
    wait_clk(3 * HP);
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && (ram_we || reg_stb)) begin
      int got;
      int e;
      checks++;
      if (ram_we && reg_stb) begin
        errors++;
        $display("FAIL R10: both strobes high, got we=%0b stb=%0b expected one", ram_we, reg_stb);
      end
      got = ram_we ? ((1 << 23) | (int'(ram_row) << 16) | (int'(ram_col) << 8) | int'(ram_wdata))
                   : ((int'(reg_cmd) << 16) | (int'(reg_hdr) << 8) | int'(reg_data));
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected strobe got %0h expected none", cur_req, got);
      end else begin
        e = exp_q.pop_front();
        if (got != e) begin
          errors++;
          $display("FAIL %s: got %0h expected %0h", cur_req, got, e);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check_idle(input string req);
    check_eq(req, int'(ram_we), 0);
    check_eq(req, int'(reg_stb), 0);
    check_eq(req, int'(ram_row), 0);
    check_eq(req, int'(ram_col), 0);
    check_eq(req, int'(ram_wdata), 0);
    check_eq(req, int'(reg_cmd), 0);
    check_eq(req, int'(reg_data), 0);
  endtask

  initial begin
    wait_clk(5);
    cur_req = "R9";
    check_idle("R9");
    rst = 1'b0;
    wait_clk(4);

    // default command 0 after reset, then row/column setup
    cur_req = "R4";
    cs_low();
    send_byte(8'h05);
    send_byte(8'h83);
    send_byte(8'h0A);
    cs_high();

    // character mode; 0x90 inside it is a character
    cur_req = "R5";
    cs_low();
    send_byte(8'h90);
    send_byte(8'h41);
    send_byte(8'hC2);
    send_byte(8'h90);
    cs_high();

    // wrap at last column and last row
    cur_req = "R8";
    cs_low();
    send_byte(8'h8B);
    send_byte(8'h16);
    send_byte(8'h90);
    send_byte(8'h11);
    send_byte(8'h22);
    send_byte(8'hB3);
    cs_high();

    // sticky command, index mapping
    cur_req = "R3";
    cs_low();
    send_byte(8'hA5);
    send_byte(8'h12);
    send_byte(8'h33);
    cur_req = "R2";
    send_byte(8'hF3);
    send_byte(8'h44);
    send_byte(8'hE7);
    send_byte(8'h7F);
    send_byte(8'hFA);
    send_byte(8'h01);
    cs_high();

    // out-of-range coordinates are ignored, seen through the next write
    cur_req = "R4";
    cs_low();
    send_byte(8'h82);
    send_byte(8'h04);
    send_byte(8'h8C);
    send_byte(8'h1F);
    send_byte(8'h18);
    send_byte(8'h90);
    cur_req = "R7";
    send_byte(8'h5A);
    cs_high();

    // partial word dropped on release
    cur_req = "R1";
    cs_low();
    send_bits(8'h1F, 5);
    cs_high();
    cs_low();
    send_byte(8'h90);
    send_byte(8'h66);
    cs_high();

    // release returns to command 0
    cur_req = "R6";
    cs_low();
    send_byte(8'h90);
    send_byte(8'h23);
    cs_high();
    cs_low();
    send_byte(8'h07);
    send_byte(8'h85);
    send_byte(8'h90);
    send_byte(8'h77);
    cs_high();

    // reset in the middle of character mode
    cur_req = "R9";
    cs_low();
    send_byte(8'h90);
    wait_clk(10);
    check_eq("R9", exp_q.size(), 0);
    rst = 1'b1;
    wait_clk(3);
    check_idle("R9");
    rst = 1'b0;
    model_reset();
    wait_clk(6);
    send_byte(8'h03);
    send_byte(8'h90);
    send_byte(8'h31);
    cs_high();

    wait_clk(20);
    check_eq("R7", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule